// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block takes a left/right pair of 24-bit two's-complement samples from a converter core and shifts it out, MSB first, on a three-wire serial audio link: a bit clock, a word clock that marks left and right, and one data line. Each channel occupies a 32-bit-clock slot, so a frame spans 64 bit clocks. The data line changes only after a bit-clock falling edge, which leaves the full high phase for the receiver to sample on the rising edge.

A two-bit mode input picks the clocking. With a nonzero mode the block is clock master: it divides its system clock (256, 384 or 512 times the sample rate) down to the bit clock and produces the word clock itself. With mode zero it is clock slave: it synchronises externally supplied bit and word clocks into the system-clock domain and aligns its slots to the word-clock transitions. A format input selects I2S-style framing or left-justified framing at run time. A sample pair presented with a valid strobe is held and sent in the next frame; if none arrives, the last pair is sent again.

Top module: `audio_ser_tx`

## Requirements
- R1: In master mode the bit clock period is 4, 6 or 8 system-clock cycles for `mode_i` = 01, 10, 11 respectively (256, 384, 512 fS), with equal high and low phases.
- R2: With `mode_i` = 00 (slave) `clk_oe_o` is low and `bck_o`, `lrck_o` stay low; framing follows `bck_i` and `lrck_i`.
- R3: Every channel slot spans exactly 32 bit-clock periods (64 per frame), and in master mode the word clock changes only together with a bit-clock falling edge.
- R4: The data line changes only after a bit-clock falling edge, never after a rising edge.
- R5: With `fmt_i` = 0 (I2S-style), word clock low marks the left slot and high the right slot; the sample MSB is on the second bit clock of the slot, one period after the word-clock transition.
- R6: With `fmt_i` = 1 (left-justified), word clock high marks the left slot and low the right slot; the sample MSB is on the first bit clock after the transition.
- R7: Samples go out MSB first, 24 bits per slot; every remaining bit position of the 32-bit slot is driven 0.
- R8: A pair applied with `smp_valid_i` high is taken at the start of the next left slot and sent in that frame; a frame that starts with no new pair repeats the previous pair. After reset the pair is zero.
- R9: In slave mode the block recognises a slot start when the word-clock level at a bit-clock falling edge differs from the level seen at the preceding rising edge, in either format.
- R10: During reset `bck_o`, `lrck_o` and `dout_o` are low, and `clk_oe_o` is high exactly when `mode_i` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 256/384/512 times the sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 slave; 01, 10, 11 master at 256, 384, 512 fS |
| fmt_i | input | 1 | 0 I2S-style framing, 1 left-justified framing |
| smp_l_i | input | 24 | Left sample, two's complement |
| smp_r_i | input | 24 | Right sample, two's complement |
| smp_valid_i | input | 1 | Strobe: sample pair on smp_l_i/smp_r_i is new |
| bck_i | input | 1 | External bit clock (slave mode) |
| lrck_i | input | 1 | External word clock (slave mode) |
| bck_o | output | 1 | Generated bit clock (master mode) |
| lrck_o | output | 1 | Generated word clock (master mode) |
| clk_oe_o | output | 1 | High when bck_o/lrck_o should drive the link |
| dout_o | output | 1 | Serial audio data |

## Verification
In master mode the data line and word clock are registered in the same system-clock cycle in which the bit clock falls, so each bit is stable for a whole high phase; in slave mode a bit appears three to four system-clock cycles after the external falling edge, and the bench uses a bit-clock half period of eight cycles so the bit is settled well before the rising edge it is read on. The monitor therefore samples data and word clock only at bit-clock rising edges and never at a system-clock edge. A pair strobed in one frame is due in the frame that starts at the next left-slot transition, one frame after the strobe; the driver strobes right after the monitor has seen a left-slot start, and the monitor takes the expected pair from its queue at the following left-slot start, so every comparison lines up with the frame the pair must appear in. The bit-clock period is measured in system-clock cycles between successive rising edges.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  typedef enum logic [1:0] {
    MODE_SLAVE = 2'b00,
    MODE_256   = 2'b01,
    MODE_384   = 2'b10,
    MODE_512   = 2'b11
  } clk_mode_e;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_LJ  = 1'b1
  } frame_fmt_e;

  localparam int DIV_W = 3;

  // bit-clock half period in system clocks
  function automatic logic [DIV_W-1:0] half_of(input logic [1:0] m);
    case (m)
      MODE_256: half_of = DIV_W'(2);
      MODE_384: half_of = DIV_W'(3);
      default:  half_of = DIV_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/aud_clk_master.sv
module aud_clk_master
  import aud_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             slot_end_i,
  output logic             bck_o,
  output logic             lrck_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             lrck_nx_o
);

  logic [DIV_W-1:0] div_q;
  logic             bck_q, lrck_q, wrap;

  assign wrap      = (div_q == half_i - 1'b1);
  assign rise_o    = en_i & wrap & ~bck_q;
  assign fall_o    = en_i & wrap &  bck_q;
  // level the word clock takes at this falling edge
  assign lrck_nx_o = (fall_o & slot_end_i) ? ~lrck_q : lrck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bck_q  <= 1'b0;
      lrck_q <= 1'b0;
    end else if (!en_i) begin
      div_q  <= '0;
      bck_q  <= 1'b0;
      lrck_q <= 1'b0;
    end else begin
      div_q  <= wrap ? '0 : div_q + 1'b1;
      if (wrap) bck_q <= ~bck_q;
      lrck_q <= lrck_nx_o;
    end
  end

  assign bck_o  = bck_q;
  assign lrck_o = lrck_q;

endmodule

// File: rtl/aud_clk_slave.sv
module aud_clk_slave #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bck_i,
  input  logic lrck_i,
  output logic rise_o,
  output logic fall_o,
  output logic lrck_o
);

  logic [SYNC_N-1:0] bck_s, lrck_s;
  logic              bck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_s  <= '0;
      lrck_s <= '0;
      bck_d  <= 1'b0;
    end else begin
      bck_s  <= {bck_s[SYNC_N-2:0], bck_i};
      lrck_s <= {lrck_s[SYNC_N-2:0], lrck_i};
      bck_d  <= bck_s[SYNC_N-1];
    end
  end

  assign rise_o = en_i &  bck_s[SYNC_N-1] & ~bck_d;
  assign fall_o = en_i & ~bck_s[SYNC_N-1] &  bck_d;
  assign lrck_o = lrck_s[SYNC_N-1];

endmodule

// File: rtl/aud_slot_ser.sv
module aud_slot_ser
  import aud_tx_pkg::*;
#(
  parameter int SMP_W  = 24,
  parameter int SLOT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fmt_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             lrck_i,
  input  logic [SMP_W-1:0] smp_l_i,
  input  logic [SMP_W-1:0] smp_r_i,
  input  logic             smp_valid_i,
  output logic             slot_end_o,
  output logic             dout_o
);

  localparam int POS_W = $clog2(SLOT_W);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_W - 1);

  logic [SMP_W-1:0] pend_l, pend_r, frm_l, frm_r, word, word_sh;
  logic [POS_W-1:0] pos_q, pos_n;
  logic [POS_W:0]   off;
  logic             lrck_rise_q, dout_q, new_slot, left, bit_n;

  assign new_slot = (lrck_i != lrck_rise_q);
  assign left     = (fmt_i == FMT_LJ) ? lrck_i : ~lrck_i;
  assign slot_end_o = (pos_q == POS_LAST);

  always_comb begin
    if (new_slot)             pos_n = '0;
    else if (pos_q == POS_LAST) pos_n = pos_q;
    else                      pos_n = pos_q + 1'b1;
    // data offset inside the slot; I2S delays by one bit, wrap on pos 0 yields zero
    off  = (fmt_i == FMT_LJ) ? {1'b0, pos_n} : {1'b0, pos_n} - 1'b1;
    if (new_slot && left) word = pend_l;
    else                  word = left ? frm_l : frm_r;
    word_sh = word << off;
    bit_n   = (off < (POS_W+1)'(SMP_W)) ? word_sh[SMP_W-1] : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_l      <= '0;
      pend_r      <= '0;
      frm_l       <= '0;
      frm_r       <= '0;
      pos_q       <= POS_LAST;
      lrck_rise_q <= 1'b0;
      dout_q      <= 1'b0;
    end else begin
      if (smp_valid_i) begin
        pend_l <= smp_l_i;
        pend_r <= smp_r_i;
      end
      if (rise_i) lrck_rise_q <= lrck_i;
      if (fall_i) begin
        pos_q  <= pos_n;
        dout_q <= bit_n;
        if (new_slot && left) begin
          frm_l <= pend_l;
          frm_r <= pend_r;
        end
      end
    end
  end

  assign dout_o = dout_q;

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int SMP_W  = 24,
  parameter int SLOT_W = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             fmt_i,
  input  logic [SMP_W-1:0] smp_l_i,
  input  logic [SMP_W-1:0] smp_r_i,
  input  logic             smp_valid_i,
  input  logic             bck_i,
  input  logic             lrck_i,
  output logic             bck_o,
  output logic             lrck_o,
  output logic             clk_oe_o,
  output logic             dout_o
);

  logic             master;
  logic [DIV_W-1:0] half;
  logic             m_rise, m_fall, m_lrck_nx;
  logic             s_rise, s_fall, s_lrck;
  logic             ev_rise, ev_fall, ev_lrck, slot_end;

  assign master = (mode_i != MODE_SLAVE);
  assign half   = half_of(mode_i);

  aud_clk_master u_mst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (master),
    .half_i     (half),
    .slot_end_i (slot_end),
    .bck_o      (bck_o),
    .lrck_o     (lrck_o),
    .rise_o     (m_rise),
    .fall_o     (m_fall),
    .lrck_nx_o  (m_lrck_nx)
  );

  aud_clk_slave #(.SYNC_N(SYNC_N)) u_slv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (~master),
    .bck_i  (bck_i),
    .lrck_i (lrck_i),
    .rise_o (s_rise),
    .fall_o (s_fall),
    .lrck_o (s_lrck)
  );

  assign ev_rise = master ? m_rise    : s_rise;
  assign ev_fall = master ? m_fall    : s_fall;
  assign ev_lrck = master ? m_lrck_nx : s_lrck;

  aud_slot_ser #(.SMP_W(SMP_W), .SLOT_W(SLOT_W)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fmt_i       (fmt_i),
    .rise_i      (ev_rise),
    .fall_i      (ev_fall),
    .lrck_i      (ev_lrck),
    .smp_l_i     (smp_l_i),
    .smp_r_i     (smp_r_i),
    .smp_valid_i (smp_valid_i),
    .slot_end_o  (slot_end),
    .dout_o      (dout_o)
  );

  assign clk_oe_o = master;

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       bck_o,
  input logic       lrck_o,
  input logic       clk_oe_o,
  input logic       dout_o
);

  logic mst;
  assign mst = (mode_i != 2'b00);

  // R1: each bit-clock phase lasts at least two system clocks
  p_bck_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst && $stable(mode_i) && $rose(bck_o)) |=> bck_o);

  // R2: slave mode leaves the clock outputs idle
  p_slave_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mst && $stable(mode_i)) |-> (!clk_oe_o && !bck_o && !lrck_o));

  // R3: word clock moves only with a bit-clock falling edge
  p_lrck_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst && $stable(mode_i) && !$stable(lrck_o)) |-> $fell(bck_o));

  // R4: data moves only with a bit-clock falling edge
  p_dout_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst && $stable(mode_i) && !$stable(dout_o)) |-> $fell(bck_o));

endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .bck_o    (bck_o),
  .lrck_o   (lrck_o),
  .clk_oe_o (clk_oe_o),
  .dout_o   (dout_o)
);

// File: tb/audio_ser_tx_tb_top.sv
`timescale 1ns/1ps
module audio_ser_tx_tb_top;

  typedef struct packed {
    logic [23:0] l;
    logic [23:0] r;
  } pair_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic        fmt = 1'b0;
  logic [23:0] smp_l = '0, smp_r = '0;
  logic        smp_valid = 1'b0;
  logic        tb_bck = 1'b0, tb_lr = 1'b0;
  logic        bck_o, lrck_o, clk_oe_o, dout_o;

  always #2.5 clk = ~clk;

  audio_ser_tx dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .fmt_i       (fmt),
    .smp_l_i     (smp_l),
    .smp_r_i     (smp_r),
    .smp_valid_i (smp_valid),
    .bck_i       (tb_bck),
    .lrck_i      (tb_lr),
    .bck_o       (bck_o),
    .lrck_o      (lrck_o),
    .clk_oe_o    (clk_oe_o),
    .dout_o      (dout_o)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // slave clock source: half period 8 system clocks, 32 bit clocks per slot
  bit slave_run = 0;
  int ph = 0, sc = 0;
  initial forever begin
    @(negedge clk);
    if (!slave_run) begin
      tb_bck = 1'b0; ph = 0; sc = 0;
    end else begin
      ph++;
      if (ph == 8) begin
        ph = 0;
        tb_bck = ~tb_bck;
        if (!tb_bck) begin
          sc++;
          if (sc == 32) begin sc = 0; tb_lr = ~tb_lr; end
        end
      end
    end
  end

  logic rx_bck, rx_lr;
  assign rx_bck = (mode == 2'b00) ? tb_bck : bck_o;
  assign rx_lr  = (mode == 2'b00) ? tb_lr  : lrck_o;

  // scoreboard monitor: acts as the link receiver
  pair_t       exp_q[$];
  pair_t       cur;
  bit          mon_en = 0, have = 0, pad_err = 0;
  logic        prev_lr = 1'b0;
  int          bitc = 0, nrise = 0, frames = 0;
  logic [23:0] wl = '0, wr = '0;
  event        frame_ev;

  always @(posedge rx_bck) begin
    logic lr, lft;
    int   off;
    if (mon_en) begin
      lr  = rx_lr;
      lft = fmt ? lr : ~lr;
      if (lr != prev_lr) begin
        bitc = 0;
        if (lft) begin
          if (have) begin
            frames++;
            chk(wl == cur.l, fmt ? "R6/R8" : "R5/R8", "left word", 32'(wl), 32'(cur.l));
            chk(wr == cur.r, fmt ? "R6/R8" : "R5/R8", "right word", 32'(wr), 32'(cur.r));
            chk(!pad_err, "R7", "slot padding nonzero", 32'(pad_err), 0);
            chk(nrise == 64, "R3", "bit clocks per frame", 32'(nrise), 64);
          end
          have = 1; nrise = 0; pad_err = 0; wl = '0; wr = '0;
          if (exp_q.size() > 0) cur = exp_q.pop_front();
          -> frame_ev;
        end
      end else begin
        bitc++;
      end
      nrise++;
      prev_lr = lr;
      off = fmt ? bitc : bitc - 1;
      if (off >= 0 && off < 24) begin
        if (lft) wl[23-off] = dout_o;
        else     wr[23-off] = dout_o;
      end else if (off >= 24 && dout_o) begin
        pad_err = 1;
      end
    end
  end

  // bit-clock period and slave idle watcher
  bit per_err = 0, idle_err = 0, seen_rise = 0;
  logic bck_prev = 1'b0;
  int cyc = 0, per_exp = 0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (mode != 2'b00) begin
        cyc++;
        if (bck_o && !bck_prev) begin
          if (seen_rise && cyc != per_exp) per_err = 1;
          seen_rise = 1;
          cyc = 0;
        end
      end else if (bck_o || lrck_o || clk_oe_o) begin
        idle_err = 1;
      end
    end
    bck_prev = bck_o;
  end

  function automatic pair_t mk_pair(input int i);
    pair_t p;
    case (i)
      0: begin p.l = 24'h800000; p.r = 24'h7FFFFF; end
      1: begin p.l = 24'hA5C33C; p.r = 24'h000001; end
      2: begin p.l = 24'hFFFFFF; p.r = 24'h800001; end
      default: begin p.l = 24'h13579B ^ 24'(i * 4097); p.r = 24'h2468AC + 24'(i); end
    endcase
    return p;
  endfunction

  task automatic run_cfg(input logic [1:0] m, input logic f);
    pair_t p;
    mon_en = 0;
    slave_run = 0;
    rst_n = 1'b0;
    mode = m; fmt = f;
    exp_q.delete();
    cur = '0; have = 0; frames = 0; per_err = 0; idle_err = 0; seen_rise = 0; cyc = 0;
    per_exp = 2 * (int'(m) + 1);
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(bck_o == 1'b0 && lrck_o == 1'b0 && dout_o == 1'b0, "R10", "outputs in reset",
        {29'd0, bck_o, lrck_o, dout_o}, 0);
    chk(clk_oe_o == (m != 2'b00), "R10", "clock enable in reset", 32'(clk_oe_o), 32'(m != 2'b00));
    tb_lr = f;
    prev_lr = (m == 2'b00) ? tb_lr : 1'b0;
    mon_en = 1;
    slave_run = (m == 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(frame_ev);
      if (i != 3) begin  // R8: frame after the skipped strobe repeats the pair
        p = mk_pair(i);
        exp_q.push_back(p);
        @(negedge clk);
        smp_l = p.l; smp_r = p.r; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; smp_l = '0; smp_r = '0;
      end
    end
    @(frame_ev);
    @(frame_ev);
    chk(frames >= 7, "R8", "frames compared", 32'(frames), 7);
    if (m != 2'b00) chk(!per_err && seen_rise, "R1", "bit clock period", 32'(per_err), 0);
    else            chk(!idle_err, "R2", "slave clock outputs idle", 32'(idle_err), 0);
    mon_en = 0;
    slave_run = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int m = 1; m < 4; m++) begin
      run_cfg(2'(m), 1'b0);  // R5 master I2S
      run_cfg(2'(m), 1'b1);  // R6 master left-justified
    end
    run_cfg(2'b00, 1'b0);    // R9 slave I2S
    run_cfg(2'b00, 1'b1);    // R9 slave left-justified
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule